// File: doc/BRIEF.md
# Receive Word Holding Queue

This block sits between a serial receive shifter and the logic that consumes the received words. Each time the shifter completes a word, it strobes the word in with its eight data bits, a ninth data bit and a framing-error flag. The block keeps up to two such words in arrival order. The word at the head, together with its own ninth bit and framing flag, is always shown on the outputs, and a read strobe retires it.

A data-available flag is high while at least one word is held. If a further word completes while both places are occupied and no read retires a word in that cycle, the block raises a sticky overrun flag and drops the new word. From then on it accepts no words until the receiver enable is taken low and raised again. Taking the enable low clears the overrun flag and empties the queue.

Top module: `rx_word_fifo2`

## Requirements
- R1: With the enable high and overrun clear, a word strobe into a queue holding fewer than two words is stored, and `avail` is high from the next clock edge on.
- R2: A word strobe while two words are held, with no read in the same cycle, sets `ovr` at the next edge and drops that word; the head word is unchanged.
- R3: While `ovr` is set, word strobes are ignored even when space has become free. `ovr` stays set and no new word becomes visible at the head.
- R4: A cycle with the enable low clears `ovr`, discards every held word (`avail` low at the next edge), and any word strobe in that cycle is ignored.
- R5: `avail` is high exactly while at least one word is held, and it falls at the edge that retires the last word.
- R6: `hd_data`, `hd_bit9` and `hd_ferr` all belong to the head word, and all three advance together to the next word's values at the edge of a read.
- R7: Two successive reads retire the two held words in the order they arrived.
- R8: A read strobe while the queue is empty has no effect: `avail` stays low and the next stored word appears at the head.
- R9: A word strobe and a read strobe in the same cycle are both honoured. With two words held, this retires the head, stores the new word and does not set `ovr`.
- R10: After reset `avail` and `ovr` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rx_en | input | 1 | Receiver enable; a low cycle flushes the queue and clears overrun |
| wr_vld | input | 1 | One-cycle strobe: a completed word is on the word inputs |
| wr_data | input | 8 | Data bits of the completed word |
| wr_bit9 | input | 1 | Ninth data bit of the completed word |
| wr_ferr | input | 1 | Framing-error flag of the completed word |
| rd_pop | input | 1 | One-cycle strobe: retire the head word |
| hd_data | output | 8 | Data bits of the head word |
| hd_bit9 | output | 1 | Ninth bit of the head word |
| hd_ferr | output | 1 | Framing-error flag of the head word |
| avail | output | 1 | At least one word is held |
| ovr | output | 1 | Sticky overrun flag |

## Verification
Every result is due one clock edge after the cycle in which its strobes were applied. Stores, reads, overrun setting and the flush caused by a low enable all take effect at that edge, and the head outputs follow the pointer with no further delay. The bench drives each vector on a falling edge, lets one rising edge pass, and compares `avail`, `ovr` and, where defined, the head fields at the next falling edge before it drives the next vector. Reset is the only exception. Its release passes through two synchronizing flops, so the bench waits several cycles after release before it applies the first vector.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned WORD_W = 8;

  typedef struct packed {
    logic [WORD_W-1:0] data;
    logic              bit9;
    logic              ferr;
  } rx_word_t;
endpackage

// File: rtl/rxq_rst_sync.sv
module rxq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int unsigned DEPTH = 2,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          wr_vld,
  input  logic          rd_pop,
  output logic          push,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic          avail,
  output logic          ovr
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic          ovr_q, ovr_d;
  logic          pop_ok, room, ovr_hit;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  // strobe qualification
  always_comb begin
    pop_ok  = rx_en & rd_pop & (cnt_q != '0);
    room    = (cnt_q < CW'(DEPTH)) | pop_ok;
    push    = rx_en & wr_vld & ~ovr_q & room;
    ovr_hit = rx_en & wr_vld & ~ovr_q & ~room;
  end

  // next state
  always_comb begin
    if (!rx_en) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
      ovr_d = 1'b0;
    end else begin
      wr_d  = push   ? ptr_inc(wr_q) : wr_q;
      rd_d  = pop_ok ? ptr_inc(rd_q) : rd_q;
      cnt_d = cnt_q + CW'(push) - CW'(pop_ok);
      ovr_d = ovr_q | ovr_hit;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
      ovr_q <= ovr_d;
    end
  end

  assign wr_ptr = wr_q;
  assign rd_ptr = rd_q;
  assign avail  = (cnt_q != '0);
  assign ovr    = ovr_q;
endmodule

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 2,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [PW-1:0] wr_ptr,
  input  logic [PW-1:0] rd_ptr,
  input  rx_word_t      wr_word,
  output rx_word_t      hd_word
);
  rx_word_t slot_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    rx_word_t q, d;
    logic     we;

    always_comb begin
      we = push & (wr_ptr == PW'(i));
      d  = we ? wr_word : q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end

    assign slot_q[i] = q;
  end

  always_comb begin
    hd_word = slot_q[0];
    for (int j = 1; j < DEPTH; j++) begin
      if (rd_ptr == PW'(j)) hd_word = slot_q[j];
    end
  end
endmodule

// File: rtl/rx_word_fifo2.sv
module rx_word_fifo2
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 2,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              wr_vld,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              wr_bit9,
  input  logic              wr_ferr,
  input  logic              rd_pop,
  output logic [WORD_W-1:0] hd_data,
  output logic              hd_bit9,
  output logic              hd_ferr,
  output logic              avail,
  output logic              ovr
);
  logic          rst_sync_n;
  logic          push;
  logic [PW-1:0] wr_ptr, rd_ptr;
  rx_word_t      in_word, head;

  rxq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .rx_en  (rx_en),
    .wr_vld (wr_vld),
    .rd_pop (rd_pop),
    .push   (push),
    .wr_ptr (wr_ptr),
    .rd_ptr (rd_ptr),
    .avail  (avail),
    .ovr    (ovr)
  );

  assign in_word = '{data: wr_data, bit9: wr_bit9, ferr: wr_ferr};

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .push    (push),
    .wr_ptr  (wr_ptr),
    .rd_ptr  (rd_ptr),
    .wr_word (in_word),
    .hd_word (head)
  );

  assign hd_data = head.data;
  assign hd_bit9 = head.bit9;
  assign hd_ferr = head.ferr;
endmodule

// File: rtl/rxq_chk.sv
module rxq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_en,
  input logic       wr_vld,
  input logic       rd_pop,
  input logic [7:0] hd_data,
  input logic       hd_bit9,
  input logic       hd_ferr,
  input logic       avail,
  input logic       ovr
);
  // R1: an accepted word makes data available at the next edge
  p_store_sets_avail_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && wr_vld && !ovr) |=> avail);

  // R3: overrun is sticky while enabled
  p_ovr_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && ovr) |=> ovr);

  // R3: while overrun is set and nothing is read, the head and avail do not move
  p_ovr_locks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && ovr && !rd_pop) |=> $stable({hd_data, hd_bit9, hd_ferr, avail}));

  // R4: a disabled cycle flushes and clears overrun
  p_disable_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!avail && !ovr));

  // R8: a read on an empty queue leaves it empty
  p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && !avail && rd_pop && !wr_vld) |=> !avail);
endmodule

bind rx_word_fifo2 rxq_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .rx_en   (rx_en),
  .wr_vld  (wr_vld),
  .rd_pop  (rd_pop),
  .hd_data (hd_data),
  .hd_bit9 (hd_bit9),
  .hd_ferr (hd_ferr),
  .avail   (avail),
  .ovr     (ovr)
);

// File: tb/rx_word_fifo2_tb.sv
module rx_word_fifo2_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_en, wr_vld, wr_bit9, wr_ferr, rd_pop;
  logic [7:0] wr_data;
  logic [7:0] hd_data;
  logic       hd_bit9, hd_ferr, avail, ovr;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  rx_word_fifo2 u_dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .wr_vld(wr_vld),
    .wr_data(wr_data), .wr_bit9(wr_bit9), .wr_ferr(wr_ferr), .rd_pop(rd_pop),
    .hd_data(hd_data), .hd_bit9(hd_bit9), .hd_ferr(hd_ferr),
    .avail(avail), .ovr(ovr)
  );

  typedef struct packed {
    logic       en;
    logic       vld;
    logic [7:0] d;
    logic       b9;
    logic       fe;
    logic       pop;
    logic       xa;   // expected avail
    logic       xo;   // expected ovr
    logic       hk;   // compare head fields
    logic [7:0] xd;
    logic       xb9;
    logic       xfe;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    // en vld data   b9 fe pop  xa xo hk  xd     xb9 xfe req
    '{1'b1,1'b1,8'hA5,1'b1,1'b0,1'b0, 1'b1,1'b0,1'b1, 8'hA5,1'b1,1'b0, 4'd1},  // R1 first store
    '{1'b1,1'b1,8'h3C,1'b0,1'b1,1'b0, 1'b1,1'b0,1'b1, 8'hA5,1'b1,1'b0, 4'd6},  // R6 head stays first
    '{1'b1,1'b1,8'h77,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b1, 8'hA5,1'b1,1'b0, 4'd2},  // R2 third word overruns
    '{1'b1,1'b1,8'h11,1'b1,1'b1,1'b0, 1'b1,1'b1,1'b1, 8'hA5,1'b1,1'b0, 4'd3},  // R3 write while ovr
    '{1'b1,1'b0,8'h00,1'b0,1'b0,1'b1, 1'b1,1'b1,1'b1, 8'h3C,1'b0,1'b1, 4'd7},  // R7 second word next
    '{1'b1,1'b1,8'h22,1'b1,1'b0,1'b0, 1'b1,1'b1,1'b1, 8'h3C,1'b0,1'b1, 4'd3},  // R3 space free, still locked
    '{1'b1,1'b0,8'h00,1'b0,1'b0,1'b1, 1'b0,1'b1,1'b0, 8'h00,1'b0,1'b0, 4'd5},  // R5 last read clears avail
    '{1'b1,1'b1,8'h33,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0, 8'h00,1'b0,1'b0, 4'd3},  // R3 empty and locked
    '{1'b0,1'b0,8'h00,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0, 8'h00,1'b0,1'b0, 4'd4},  // R4 disable clears ovr
    '{1'b0,1'b1,8'h44,1'b1,1'b1,1'b0, 1'b0,1'b0,1'b0, 8'h00,1'b0,1'b0, 4'd4},  // R4 write while disabled
    '{1'b1,1'b1,8'h55,1'b0,1'b1,1'b0, 1'b1,1'b0,1'b1, 8'h55,1'b0,1'b1, 4'd1},  // R1 store after re-enable
    '{1'b1,1'b1,8'h66,1'b1,1'b0,1'b1, 1'b1,1'b0,1'b1, 8'h66,1'b1,1'b0, 4'd9},  // R9 write+read, one held
    '{1'b1,1'b1,8'h77,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1, 8'h66,1'b1,1'b0, 4'd1},  // R1 fill to two
    '{1'b1,1'b1,8'h88,1'b1,1'b1,1'b1, 1'b1,1'b0,1'b1, 8'h77,1'b0,1'b0, 4'd9},  // R9 write+read when full
    '{1'b1,1'b0,8'h00,1'b0,1'b0,1'b1, 1'b1,1'b0,1'b1, 8'h88,1'b1,1'b1, 4'd6},  // R6 status advances
    '{1'b1,1'b0,8'h00,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b0, 8'h00,1'b0,1'b0, 4'd5},  // R5 empty again
    '{1'b1,1'b0,8'h00,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b0, 8'h00,1'b0,1'b0, 4'd8},  // R8 read on empty
    '{1'b1,1'b1,8'h99,1'b1,1'b0,1'b0, 1'b1,1'b0,1'b1, 8'h99,1'b1,1'b0, 4'd8},  // R8 next store is head
    '{1'b1,1'b0,8'h00,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b0, 8'h00,1'b0,1'b0, 4'd5}   // R5 drained
  };

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic en, input logic vld, input logic [7:0] d,
                       input logic b9, input logic fe, input logic pop);
    rx_en = en; wr_vld = vld; wr_data = d; wr_bit9 = b9; wr_ferr = fe; rd_pop = pop;
    @(posedge clk);
    @(negedge clk);
    rx_en = 1'b1; wr_vld = 1'b0; rd_pop = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_en = 1'b1; wr_vld = 1'b0; rd_pop = 1'b0;
    wr_data = '0; wr_bit9 = 1'b0; wr_ferr = 1'b0;
    idle(3);
    check("R10 reset avail/ovr", {8'd0, avail, ovr}, 10'd0);
    rst_n = 1'b1;
    idle(4);
    check("R10 after release", {8'd0, avail, ovr}, 10'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].en, VEC[i].vld, VEC[i].d, VEC[i].b9, VEC[i].fe, VEC[i].pop);
      check($sformatf("R%0d vec%0d avail/ovr", VEC[i].req, i),
            {8'd0, avail, ovr}, {8'd0, VEC[i].xa, VEC[i].xo});
      if (VEC[i].hk)
        check($sformatf("R%0d vec%0d head", VEC[i].req, i),
              {hd_data, hd_bit9, hd_ferr}, {VEC[i].xd, VEC[i].xb9, VEC[i].xfe});
    end

    // R4: toggling the enable flushes held words without overrun
    drive(1'b1, 1'b1, 8'hC1, 1'b0, 1'b0, 1'b0);
    drive(1'b1, 1'b1, 8'hC2, 1'b0, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    check("R4 flush of two words", {8'd0, avail, ovr}, 10'd0);
    drive(1'b1, 1'b1, 8'hD4, 1'b1, 1'b1, 1'b0);
    check("R4 fresh word after flush", {hd_data, hd_bit9, hd_ferr}, {8'hD4, 1'b1, 1'b1});

    // R2: overrun with the dropped word never reaching the head
    drive(1'b1, 1'b1, 8'hE5, 1'b0, 1'b0, 1'b0);
    drive(1'b1, 1'b1, 8'hF6, 1'b1, 1'b0, 1'b0);
    check("R2 ovr set", {8'd0, avail, ovr}, 10'b11);
    drive(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    check("R2 second word kept", {hd_data, hd_bit9, hd_ferr}, {8'hE5, 1'b0, 1'b0});
    drive(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    check("R2 dropped word absent", {8'd0, avail, ovr}, 10'b01);

    // R10: reset asserted mid-run with overrun set
    rst_n = 1'b0;
    idle(2);
    check("R10 mid-run reset", {8'd0, avail, ovr}, 10'd0);
    rst_n = 1'b1;
    idle(4);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule